// File: doc/BRIEF.md
# Request-Acknowledge Timeout Monitor

This block is a synthesizable protocol checker. It sits beside a bus that has one transaction in flight at a time and no pipelining. Each cycle it samples the chip-select request `csel` and the acknowledge `ack`. It opens one check per transaction and reports one of three results: the acknowledge arrived in time, the wait ran too long, or the handshake was misused.

Checks are gated by a busy lock, not by an edge detector. A check can open only when the lock is clear, and the check sets the lock when it opens. The lock is released in the cycle the check ends, whether the check passes or times out. Because of this, a request that stays high across several transactions opens a new check after each acknowledge. A request that is withdrawn and reissued while a check is still open does not open a second check. It is reported as an overlap instead. All results appear as one-cycle pulses, one clock after the cycle that decides them.

Top module: `hs_ack_monitor`

## Requirements
- R1: While synchronous active-high `rst` is sampled high, the next clock edge clears `busy_o`, `pass_o`, `timeout_o` and `overlap_o`.
- R2: When idle (`busy_o` low), a cycle with `csel` and `ack` both high pulses `pass_o` for one cycle after the edge and leaves `busy_o` low.
- R3: When idle, a cycle with `csel` high and `ack` low opens a check: `busy_o` is high after that edge.
- R4: When busy, a cycle with `ack` high pulses `pass_o` after the edge and clears `busy_o`, whatever `csel` is.
- R5: A check opened at edge t passes if `ack` is first sampled high at any edge from t+1 to t+MAX_WAIT (MAX_WAIT defaults to 10). If `ack` is still low at edge t+MAX_WAIT, `timeout_o` pulses after that edge and `busy_o` clears.
- R6: When `csel` is held high across consecutive transactions, the first sampled cycle after a check ends (by pass or by timeout) opens a fresh check.
- R7: When busy, a cycle that is not the closing one (`ack` low and the window not spent), with `csel` high after being low on the previous edge, pulses `overlap_o`. It does not restart the wait window.
- R8: When idle, `ack` high with `csel` low pulses `overlap_o`.
- R9: In any cycle, at most one of `pass_o`, `timeout_o` and `overlap_o` is high.
- R10: A reissued request sampled in the same cycle that a check closes with `ack` gives `pass_o` only, with no `overlap_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| csel | input | 1 | Chip-select request from the bus |
| ack | input | 1 | Acknowledge from the bus |
| pass_o | output | 1 | One-cycle pulse: handshake finished in time |
| timeout_o | output | 1 | One-cycle pulse: acknowledge window spent |
| overlap_o | output | 1 | One-cycle pulse: reissued request while busy, or stray acknowledge |
| busy_o | output | 1 | A check is open |

## Verification
The assertions expect `csel` and `ack` to be stable, known values at each rising edge. They also expect `rst` to be held for at least one edge before any other check is meaningful. The bench changes inputs only on falling edges and starts with two reset cycles. It does not need to keep to a legal bus: stray acknowledges and reissued requests are driven on purpose, because the monitor must classify them rather than assume they never happen.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;

  // Width that counts 0..max_wait-1, never narrower than 4 bits.
  function automatic int unsigned wait_cnt_width(int unsigned max_wait);
    int unsigned w;
    w = (max_wait > 1) ? $clog2(max_wait) : 1;
    return (w < 4) ? 4 : w;
  endfunction

  // Result events of one sampled cycle.
  typedef struct packed {
    logic ok;
    logic late;
    logic clash;
  } hs_result_t;

endpackage

// File: rtl/hs_event_decode.sv
module hs_event_decode (
  input  logic busy,
  input  logic csel,
  input  logic ack,
  input  logic csel_q,
  input  logic expire,
  output logic start,
  output logic finish,
  output hs_mon_pkg::hs_result_t res
);
  logic idle_req_ack;
  logic busy_ack;
  logic busy_spent;
  logic reissue;
  logic stray_ack;

  always_comb begin
    idle_req_ack = !busy && csel && ack;
    busy_ack     = busy && ack;
    busy_spent   = busy && !ack && expire;
    reissue      = busy && !ack && !expire && csel && !csel_q;
    stray_ack    = !busy && !csel && ack;
    start        = !busy && csel && !ack;
    finish       = busy_ack || busy_spent;
    res.ok       = idle_req_ack || busy_ack;
    res.late     = busy_spent;
    res.clash    = reissue || stray_ack;
  end
endmodule

// File: rtl/hs_wait_timer.sv
module hs_wait_timer #(
  parameter int unsigned MAX_WAIT = 10,
  parameter int unsigned CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             busy,
  input  logic             ack,
  output logic [CNT_W-1:0] elapsed,
  output logic             expire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_WAIT - 1);

  always_comb expire = busy && (elapsed == LAST);

  always_ff @(posedge clk) begin
    if (rst)                          elapsed <= '0;
    else if (start)                   elapsed <= '0;
    else if (busy && !ack && !expire) elapsed <= elapsed + 1'b1;
  end

  // R5
  cnt_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    elapsed <= LAST);
endmodule

// File: rtl/hs_busy_lock.sv
module hs_busy_lock (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic finish,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst)         busy <= 1'b0;
    else if (start)  busy <= 1'b1;
    else if (finish) busy <= 1'b0;
  end

  // R3
  start_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/hs_ack_monitor.sv
module hs_ack_monitor #(
  parameter int unsigned MAX_WAIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic csel,
  input  logic ack,
  output logic pass_o,
  output logic timeout_o,
  output logic overlap_o,
  output logic busy_o
);
  import hs_mon_pkg::*;
  localparam int unsigned CNT_W = wait_cnt_width(MAX_WAIT);

  logic             csel_q;
  logic             start_w;
  logic             finish_w;
  logic             expire_w;
  logic [CNT_W-1:0] elapsed_w;
  hs_result_t       res_w;

  always_ff @(posedge clk) begin
    if (rst) csel_q <= 1'b0;
    else     csel_q <= csel;
  end

  hs_event_decode u_decode (
    .busy   (busy_o),
    .csel   (csel),
    .ack    (ack),
    .csel_q (csel_q),
    .expire (expire_w),
    .start  (start_w),
    .finish (finish_w),
    .res    (res_w)
  );

  hs_wait_timer #(.MAX_WAIT(MAX_WAIT), .CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (start_w),
    .busy    (busy_o),
    .ack     (ack),
    .elapsed (elapsed_w),
    .expire  (expire_w)
  );

  hs_busy_lock u_lock (
    .clk    (clk),
    .rst    (rst),
    .start  (start_w),
    .finish (finish_w),
    .busy   (busy_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_o    <= 1'b0;
      timeout_o <= 1'b0;
      overlap_o <= 1'b0;
    end else begin
      pass_o    <= res_w.ok;
      timeout_o <= res_w.late;
      overlap_o <= res_w.clash;
    end
  end

  // R4
  ack_closes_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o && ack |=> pass_o && !busy_o);

  // R3
  req_opens_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o && csel && !ack |=> busy_o);

  // R9
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pass_o, timeout_o, overlap_o}));

  // R5
  timeout_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_o) |-> $past(busy_o && !ack) && !busy_o);

  // R8
  stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o && ack && !csel |=> overlap_o);

  // R10
  close_no_clash_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o && ack |=> !overlap_o);
endmodule

// File: tb/hs_ack_monitor_tb_top.sv
module hs_ack_monitor_tb_top;
  localparam int unsigned MAXW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csel = 1'b0;
  logic ack = 1'b0;
  logic pass_o, timeout_o, overlap_o, busy_o;

  always #5 clk = ~clk;

  hs_ack_monitor #(.MAX_WAIT(MAXW)) dut_i (
    .clk(clk), .rst(rst), .csel(csel), .ack(ack),
    .pass_o(pass_o), .timeout_o(timeout_o),
    .overlap_o(overlap_o), .busy_o(busy_o)
  );

  typedef struct {
    logic [3:0] want; // {pass, timeout, overlap, busy}
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // Bench's own view of the protocol: samples still allowed in the window.
  bit m_open = 0;
  int m_left = 0;
  bit m_prev = 0;

  task automatic step(input bit r, input bit c, input bit a, input string tag);
    exp_t e;
    bit p = 0, t = 0, o = 0;
    @(negedge clk);
    rst = r; csel = c; ack = a;
    if (r) begin
      m_open = 0; m_prev = 0;
    end else begin
      if (!m_open) begin
        if (c && a) p = 1;
        else if (c) begin m_open = 1; m_left = MAXW; end
        else if (a) o = 1;
      end else if (a) begin
        p = 1; m_open = 0;
      end else if (m_left == 1) begin
        t = 1; m_open = 0;
      end else begin
        m_left--;
        if (c && !m_prev) o = 1;
      end
      m_prev = c;
    end
    e.want = {p, t, o, m_open};
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare after each edge settles.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        logic [3:0] got;
        e = exp_q.pop_front();
        got = {pass_o, timeout_o, overlap_o, busy_o};
        total++;
        if (got !== e.want) begin
          bad++;
          $display("FAIL %s: got p/t/o/b=%b expected %b", e.tag, got, e.want);
        end
        total++;
        if ($countones({pass_o, timeout_o, overlap_o}) > 1) begin
          bad++;
          $display("FAIL R9: got results=%b expected at most one set",
                   {pass_o, timeout_o, overlap_o});
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got no finish expected end of run");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset
    step(1, 1, 1, "R1");
    step(1, 0, 0, "R1");
    step(0, 0, 0, "R1");
    // R2 immediate answer
    step(0, 1, 1, "R2");
    step(0, 0, 0, "R2");
    // R3 / R4 short wait
    step(0, 1, 0, "R3");
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R4");
    step(0, 1, 1, "R4");
    step(0, 0, 0, "R4");
    // R5 boundary pass at last allowed edge, csel held (R6 afterwards)
    step(0, 1, 0, "R5");
    for (int i = 0; i < MAXW - 1; i++) step(0, 1, 0, "R5");
    step(0, 1, 1, "R5");
    step(0, 1, 0, "R6");
    for (int i = 0; i < MAXW; i++) step(0, 1, 0, "R5");
    // held csel after timeout opens fresh check
    step(0, 1, 0, "R6");
    step(0, 1, 0, "R6");
    step(0, 1, 1, "R6");
    step(0, 0, 0, "R6");
    // R8 stray acknowledge
    step(0, 0, 1, "R8");
    step(0, 0, 0, "R8");
    // R7 reissue while busy, window not restarted
    step(0, 1, 0, "R7");
    step(0, 0, 0, "R7");
    step(0, 1, 0, "R7");
    for (int i = 0; i < MAXW - 2; i++) step(0, 1, 0, "R7");
    step(0, 0, 0, "R7");
    // R10 reissue in closing cycle
    step(0, 1, 0, "R10");
    step(0, 0, 0, "R10");
    step(0, 1, 1, "R10");
    step(0, 0, 0, "R10");
    // R1 reset mid-check
    step(0, 1, 0, "R1");
    step(1, 0, 0, "R1");
    step(0, 0, 0, "R1");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule